// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits next to a timer counter and decides, cycle by cycle, whether that counter advances, in which direction, and when it is restarted or launched. A 3-bit mode input chooses one of eight behaviours: free running on the internal clock, three quadrature-encoder variants, restart on a trigger rising edge, gating by the trigger level, a one-shot start from a trigger edge, and stepping the counter once per trigger edge. A separate select input picks the trigger from a vector of sources.

Every trigger source and both encoder inputs pass through a two-flop synchroniser and then an edge detector. An input change therefore reaches the outputs two clock cycles after the cycle in which it was applied. The counter is outside the block and only consumes the four request outputs. The mode and select inputs act on the outputs in the same cycle.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: In mode 0, `cnt_en_o` is high every cycle, `cnt_dir_o` is 1 (up), and `cnt_rst_o` and `cnt_start_o` stay low. Direction is 1 in every mode other than 1 to 3.
- R2: In mode 1, each change of `enc_b_i` gives a one-cycle `cnt_en_o`. The count is up when the new B level equals the A level and down otherwise. A change of A alone gives no count.
- R3: In mode 2, each change of `enc_a_i` gives a one-cycle `cnt_en_o`. The count is up when the new A level differs from the B level and down otherwise. A change of B alone gives no count.
- R4: In mode 3, a change of either input counts, using the direction rule of R2 or R3 for the input that changed. If both inputs change in the same cycle, there is no count.
- R5: In mode 4, `cnt_en_o` stays high every cycle. Each rising edge of the selected trigger gives a one-cycle `cnt_rst_o` pulse.
- R6: In mode 5, `cnt_en_o` equals the synchronised level of the selected trigger, and no reset request is made.
- R7: In mode 6, a rising edge of the selected trigger gives a one-cycle `cnt_start_o` pulse. From that cycle on, `cnt_en_o` stays high while the mode remains 6, and a trigger fall does not stop it. Leaving mode 6 clears the started state.
- R8: In mode 7, each rising edge of the selected trigger gives exactly one cycle of `cnt_en_o`. A high level and a falling edge give none.
- R9: Only the source chosen by `tsel_i` (bit index into `trig_i`) takes effect. Switching the select to a source that is already high creates no edge.
- R10: An input change applied in cycle k shows at the outputs in cycle k+2. In modes 1 to 3, `cnt_dir_o` keeps the direction of the last count while no count occurs.
- R11: While `rst_ni` is low, the started state is cleared, the held direction is up, and no edge is reported. In mode 6 the outputs are en=0, dir=1, rst=0, start=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Slave mode, 0 to 7 |
| tsel_i | input | SEL_W | Trigger source select |
| trig_i | input | NUM_TRIG | Trigger source vector |
| enc_a_i | input | 1 | Encoder input A |
| enc_b_i | input | 1 | Encoder input B |
| cnt_en_o | output | 1 | Counter advance strobe |
| cnt_dir_o | output | 1 | Count direction, 1 = up |
| cnt_rst_o | output | 1 | Counter reinitialise and update request |
| cnt_start_o | output | 1 | Counter start request |

## Verification
In restart mode, the reset request coincides with the internal-clock advance strobe. In start mode, the start pulse coincides with the first enable. The bench raises the selected trigger while each mode runs and expects both outputs high in the same cycle, two cycles after the stimulus. A third collision is both encoder inputs toggling in one cycle in mode 3. This is provoked directly, and the expected result is no count with the held direction unchanged.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;
  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_ENC_B  = 3'd1,
    SM_ENC_A  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCLK = 3'd7
  } slave_mode_e;

  function automatic logic is_enc_mode(slave_mode_e m);
    return (m == SM_ENC_B) || (m == SM_ENC_A) || (m == SM_ENC_AB);
  endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= d_i;
  end

  assign cur_o  = d_i;
  assign prev_o = prev_q;
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec
  import tmr_slave_pkg::*;
(
  input  slave_mode_e mode_i,
  input  logic        a_cur_i,
  input  logic        a_prev_i,
  input  logic        b_cur_i,
  input  logic        b_prev_i,
  output logic        step_o,
  output logic        up_o
);
  logic a_chg, b_chg, step_a, step_b, up_a, up_b;

  assign a_chg  = a_cur_i ^ a_prev_i;
  assign b_chg  = b_cur_i ^ b_prev_i;
  // both moving in one cycle is an illegal transition
  assign step_a = a_chg & ~b_chg;
  assign step_b = b_chg & ~a_chg;
  assign up_a   = a_cur_i != b_cur_i;
  assign up_b   = b_cur_i == a_cur_i;

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      SM_ENC_B: begin
        step_o = step_b;
        up_o   = up_b;
      end
      SM_ENC_A: begin
        step_o = step_a;
        up_o   = up_a;
      end
      SM_ENC_AB: begin
        step_o = step_a | step_b;
        up_o   = step_a ? up_a : up_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int NUM_TRIG    = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic [SEL_W-1:0]    tsel_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                enc_a_i,
  input  logic                enc_b_i,
  output logic                cnt_en_o,
  output logic                cnt_dir_o,
  output logic                cnt_rst_o,
  output logic                cnt_start_o
);
  localparam int IN_W       = NUM_TRIG + 2;
  localparam int TRIG_SPAN  = 1 << SEL_W;

  slave_mode_e mode;
  assign mode = slave_mode_e'(mode_i);

  logic [IN_W-1:0] raw_in, sync_in, cur_in, prev_in;
  assign raw_in = {enc_a_i, enc_b_i, trig_i};

  tmr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  tmr_edge #(.WIDTH(IN_W)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_in),
    .cur_o (cur_in),
    .prev_o(prev_in)
  );

  // trigger selection over a select-sized span, unused slots read low
  logic [TRIG_SPAN-1:0] trig_cur_ext, trig_prev_ext;
  always_comb begin
    trig_cur_ext  = '0;
    trig_prev_ext = '0;
    trig_cur_ext[NUM_TRIG-1:0]  = cur_in[NUM_TRIG-1:0];
    trig_prev_ext[NUM_TRIG-1:0] = prev_in[NUM_TRIG-1:0];
  end

  logic trig_lvl, trig_rise;
  assign trig_lvl  = trig_cur_ext[tsel_i];
  assign trig_rise = trig_lvl & ~trig_prev_ext[tsel_i];

  logic enc_step, enc_up;
  tmr_quad_dec u_quad (
    .mode_i  (mode),
    .a_cur_i (cur_in[IN_W-1]),
    .a_prev_i(prev_in[IN_W-1]),
    .b_cur_i (cur_in[IN_W-2]),
    .b_prev_i(prev_in[IN_W-2]),
    .step_o  (enc_step),
    .up_o    (enc_up)
  );

  logic dir_q, started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= 1'b1;
      started_q <= 1'b0;
    end else begin
      if (is_enc_mode(mode) && enc_step) dir_q <= enc_up;
      started_q <= (mode == SM_START) && (started_q || trig_rise);
    end
  end

  always_comb begin
    cnt_en_o    = 1'b0;
    cnt_dir_o   = 1'b1;
    cnt_rst_o   = 1'b0;
    cnt_start_o = 1'b0;
    unique case (mode)
      SM_OFF: cnt_en_o = 1'b1;
      SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin
        cnt_en_o  = enc_step;
        cnt_dir_o = enc_step ? enc_up : dir_q;
      end
      SM_RESET: begin
        cnt_en_o  = 1'b1;
        cnt_rst_o = trig_rise;
      end
      SM_GATED: cnt_en_o = trig_lvl;
      SM_START: begin
        cnt_en_o    = started_q | trig_rise;
        cnt_start_o = trig_rise;
      end
      SM_EXTCLK: cnt_en_o = trig_rise;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_slave_ctrl_chk.sv
module tmr_slave_ctrl_chk
  import tmr_slave_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic [SEL_W-1:0] tsel_i,
  input logic             cnt_en_o,
  input logic             cnt_dir_o,
  input logic             cnt_rst_o,
  input logic             cnt_start_o
);
  logic enc_now;
  assign enc_now = (mode_i == 3'd1) || (mode_i == 3'd2) || (mode_i == 3'd3);

  // R1
  off_free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |-> (cnt_en_o && cnt_dir_o && !cnt_rst_o && !cnt_start_o));

  // R5
  reset_req_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> (mode_i == 3'd4 && cnt_en_o));

  // R7
  start_req_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_start_o |-> (mode_i == 3'd6 && cnt_en_o && !cnt_rst_o));

  // R7
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6 && cnt_en_o) |=> (mode_i != 3'd6 || cnt_en_o));

  // R8
  ext_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd7 && cnt_en_o) |=> !(mode_i == 3'd7 && cnt_en_o && $stable(tsel_i)));

  // R10
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_now && $past(enc_now) && !cnt_en_o) |-> $stable(cnt_dir_o));
endmodule

bind tmr_slave_ctrl tmr_slave_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .tsel_i     (tsel_i),
  .cnt_en_o   (cnt_en_o),
  .cnt_dir_o  (cnt_dir_o),
  .cnt_rst_o  (cnt_rst_o),
  .cnt_start_o(cnt_start_o)
);

// File: tb/tmr_slave_ctrl_tb.sv
module tmr_slave_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd6;
  logic [2:0] tsel = 3'd0;
  logic [7:0] trig = 8'd0;
  logic       enc_a = 1'b0, enc_b = 1'b0;
  logic       cnt_en, cnt_dir, cnt_rst, cnt_start;

  logic       n_rst = 1'b0;
  logic [2:0] n_mode = 3'd6;
  logic [2:0] n_tsel = 3'd0;
  logic [7:0] n_trig = 8'd0;
  logic       n_a = 1'b0, n_b = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_slave_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .tsel_i     (tsel),
    .trig_i     (trig),
    .enc_a_i    (enc_a),
    .enc_b_i    (enc_b),
    .cnt_en_o   (cnt_en),
    .cnt_dir_o  (cnt_dir),
    .cnt_rst_o  (cnt_rst),
    .cnt_start_o(cnt_start)
  );

  // driver: apply pending inputs after the edge, push the expected tuple {en,dir,rst,start}
  task automatic cyc(input logic [3:0] e, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    rst_n = n_rst; mode = n_mode; tsel = n_tsel; trig = n_trig;
    enc_a = n_a; enc_b = n_b;
    it.v = e;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        logic [3:0] got;
        it  = exp_q.pop_front();
        got = {cnt_en, cnt_dir, cnt_rst, cnt_start};
        checks++;
        if (got !== it.v) begin
          fails++;
          $display("FAIL %s: got en,dir,rst,start=%b expected %b at %0t", it.tag, got, it.v, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state, mode 6
    cyc(4'b0100, "R11"); cyc(4'b0100, "R11");
    n_rst = 1'b1;
    cyc(4'b0100, "R11");
    // R1 free running
    n_mode = 3'd0;
    cyc(4'b1100, "R1"); cyc(4'b1100, "R1"); cyc(4'b1100, "R1");

    // R5 restart on trigger 2, concurrent with enable
    n_mode = 3'd4; n_tsel = 3'd2;
    cyc(4'b1100, "R5"); cyc(4'b1100, "R5");
    n_trig = 8'b0000_0100;
    cyc(4'b1100, "R10"); cyc(4'b1100, "R10"); cyc(4'b1110, "R5"); cyc(4'b1100, "R5"); cyc(4'b1100, "R5");
    // R9 unselected source rising
    n_trig = 8'b0010_0100;
    cyc(4'b1100, "R9"); cyc(4'b1100, "R9"); cyc(4'b1100, "R9"); cyc(4'b1100, "R9");
    // R9 switch select onto an already high source
    n_tsel = 3'd5;
    cyc(4'b1100, "R9"); cyc(4'b1100, "R9"); cyc(4'b1100, "R9");
    n_trig = 8'd0;
    cyc(4'b1100, "R5"); cyc(4'b1100, "R5"); cyc(4'b1100, "R5");

    // R6 gated on trigger 5
    n_mode = 3'd5;
    cyc(4'b0100, "R6"); cyc(4'b0100, "R6");
    n_trig = 8'b0010_0000;
    cyc(4'b0100, "R6"); cyc(4'b0100, "R6"); cyc(4'b1100, "R6"); cyc(4'b1100, "R6");
    n_trig = 8'd0;
    cyc(4'b1100, "R6"); cyc(4'b1100, "R6"); cyc(4'b0100, "R6"); cyc(4'b0100, "R6");

    // R7 start on trigger 5
    n_mode = 3'd6;
    cyc(4'b0100, "R7");
    n_trig = 8'b0010_0000;
    cyc(4'b0100, "R7"); cyc(4'b0100, "R7"); cyc(4'b1101, "R7"); cyc(4'b1100, "R7"); cyc(4'b1100, "R7");
    n_trig = 8'd0;
    cyc(4'b1100, "R7"); cyc(4'b1100, "R7"); cyc(4'b1100, "R7"); cyc(4'b1100, "R7");
    n_mode = 3'd0;
    cyc(4'b1100, "R1");
    n_mode = 3'd6;
    cyc(4'b0100, "R7"); cyc(4'b0100, "R7");

    // R8 external clock on trigger 1
    n_mode = 3'd7; n_tsel = 3'd1;
    cyc(4'b0100, "R8");
    n_trig = 8'b0000_0010;
    cyc(4'b0100, "R8"); cyc(4'b0100, "R8"); cyc(4'b1100, "R8"); cyc(4'b0100, "R8"); cyc(4'b0100, "R8");
    n_trig = 8'd0;
    cyc(4'b0100, "R8"); cyc(4'b0100, "R8"); cyc(4'b0100, "R8"); cyc(4'b0100, "R8");
    n_trig = 8'b0000_0010;
    cyc(4'b0100, "R8"); cyc(4'b0100, "R8"); cyc(4'b1100, "R8"); cyc(4'b0100, "R8");
    n_trig = 8'd0;
    cyc(4'b0100, "R8"); cyc(4'b0100, "R8"); cyc(4'b0100, "R8");

    // R2 count on B edges
    n_mode = 3'd1;
    cyc(4'b0100, "R2");
    n_a = 1'b1;
    cyc(4'b0100, "R2"); cyc(4'b0100, "R2"); cyc(4'b0100, "R2"); cyc(4'b0100, "R2");
    n_b = 1'b1;
    cyc(4'b0100, "R2"); cyc(4'b0100, "R2"); cyc(4'b1100, "R2"); cyc(4'b0100, "R2");
    n_b = 1'b0;
    cyc(4'b0100, "R2"); cyc(4'b0100, "R2"); cyc(4'b1000, "R2"); cyc(4'b0000, "R10"); cyc(4'b0000, "R10");

    // R3 count on A edges
    n_mode = 3'd2;
    cyc(4'b0000, "R10");
    n_b = 1'b1;
    cyc(4'b0000, "R3"); cyc(4'b0000, "R3"); cyc(4'b0000, "R3"); cyc(4'b0000, "R3");
    n_a = 1'b0;
    cyc(4'b0000, "R3"); cyc(4'b0000, "R3"); cyc(4'b1100, "R3"); cyc(4'b0100, "R3");
    n_a = 1'b1;
    cyc(4'b0100, "R3"); cyc(4'b0100, "R3"); cyc(4'b1000, "R3"); cyc(4'b0000, "R3");

    // R4 both edges, illegal double change
    n_mode = 3'd3;
    cyc(4'b0000, "R4");
    n_b = 1'b0;
    cyc(4'b0000, "R4"); cyc(4'b0000, "R4"); cyc(4'b1000, "R4"); cyc(4'b0000, "R4");
    n_a = 1'b0;
    cyc(4'b0000, "R4"); cyc(4'b0000, "R4"); cyc(4'b1000, "R4"); cyc(4'b0000, "R4");
    n_a = 1'b1;
    cyc(4'b0000, "R4"); cyc(4'b0000, "R4"); cyc(4'b1100, "R4"); cyc(4'b0100, "R4");
    n_a = 1'b0; n_b = 1'b1;
    cyc(4'b0100, "R4"); cyc(4'b0100, "R4"); cyc(4'b0100, "R4"); cyc(4'b0100, "R4");

    n_mode = 3'd0;
    cyc(4'b1100, "R1"); cyc(4'b1100, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule